// File: doc/BRIEF.md
# Programmable Frame Sync Generator

This block produces the frame-synchronization level for a serial port. It runs on the system clock but moves forward only on cycles where a one-cycle strobe marks a bit-clock period, so every length below is counted in strobes. In free-running mode the frame repeats every `periodField + 1` strobes. Each frame starts with an active pulse that lasts `widthField + 1` strobes.

The period and the pulse width come from two independent down-counters. Both counters reload when the period counter expires, so a field value that is rewritten mid-frame only takes effect at the next frame start. In triggered mode the period field is ignored, and a rising edge on the external sync input, sampled on a strobe, starts each pulse. When enable is low the output is forced inactive and both counters return to their reload state.

Top module: `frame_sync_gen`

## Requirements
- R1: In free-running mode (syncMode=0, enable=1), a pulse starts every periodField+1 strobes. The first pulse starts on the first strobe after enable, reset or leaving triggered mode.
- R2: frameSync is high (1 = active) for widthField+1 strobes from the start of each pulse, counting the starting strobe, whenever widthField < periodField.
- R3: When widthField >= periodField, frameSync stays continuously high while free-running.
- R4: periodField and widthField are captured only when a pulse starts. Changing them at any other time neither truncates nor lengthens the current frame or pulse.
- R5: With syncMode=1, each strobe that sees extSync=1 while the value seen on the previous strobe was 0 starts a pulse of widthField+1 strobes. periodField has no effect in this mode.
- R6: frameSync changes only on the clock edge that ends a cycle in which bitTick=1, except when enable is low.
- R7: enable=0 drives frameSync low at the next clock edge. The first strobe after enable returns starts a pulse.
- R8: After reset frameSync is low. With both fields at zero, the output is active on every strobe (period 1, width 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitTick | input | 1 | One-cycle strobe marking each bit-clock period |
| enable | input | 1 | Generator enable; low forces idle |
| syncMode | input | 1 | 1 = externally triggered framing, 0 = free-running |
| periodField | input | 12 | Frame period minus one, in strobes |
| widthField | input | 8 | Pulse width minus one, in strobes |
| extSync | input | 1 | External trigger; rising edge sampled on strobes |
| frameSync | output | 1 | Frame-sync level, high = active |

## Verification
frameSync is a register. The value caused by a strobe, or by enable going low, therefore appears one clock edge later: it is due at the falling edge that follows the rising edge which consumed the stimulus. The bench drives every input at a falling edge and updates its reference model with those same inputs. It then waits exactly one full clock and compares at the next falling edge, so each comparison lines up with the one register stage.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  parameter int PER_W = 12;
  parameter int WID_W = 8;

  // Strobes from the control to the datapath, all for the current clock.
  typedef struct packed {
    logic clrAll;   // force idle: both counters to zero, output low
    logic clrPer;   // hold the period counter at its reload state
    logic loadPer;  // frame start: reload the period counter
    logic decPer;   // count the period down
    logic loadWid;  // pulse start: reload the width counter
    logic decWid;   // count the width down
    logic fsSet;    // drive the output active
    logic fsClr;    // drive the output inactive
  } fsgCtrlT;

endpackage

// File: rtl/fsg_downcnt.sv
module fsg_downcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] count,
  output logic         isZero
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      count <= '0;
    else if (clr)   count <= '0;
    else if (load)  count <= loadVal;
    else if (dec)   count <= count - ONE;
  end

  assign isZero = (count == '0);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (dec && !clr && !load) |-> !isZero); // R1

endmodule

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
  import fsg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitTick,
  input  logic    enable,
  input  logic    syncMode,
  input  logic    extSync,
  input  logic    perZero,
  input  logic    widZero,
  output fsgCtrlT ctrl
);

  logic extPrev;
  logic extRise;

  // Edge detection runs in the bit-clock domain: sampled on strobes only.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        extPrev <= 1'b0;
    else if (bitTick) extPrev <= extSync;
  end

  assign extRise = extSync && !extPrev;

  always_comb begin
    ctrl = '0;
    if (!enable) begin
      ctrl.clrAll = 1'b1;
    end else begin
      ctrl.clrPer = syncMode;
      if (bitTick) begin
        if (syncMode) begin
          if (extRise) begin
            ctrl.loadWid = 1'b1;
            ctrl.fsSet   = 1'b1;
          end else if (!widZero) begin
            ctrl.decWid = 1'b1;
            ctrl.fsSet  = 1'b1;
          end else begin
            ctrl.fsClr = 1'b1;
          end
        end else if (perZero) begin
          ctrl.loadPer = 1'b1;
          ctrl.loadWid = 1'b1;
          ctrl.fsSet   = 1'b1;
        end else begin
          ctrl.decPer = 1'b1;
          if (!widZero) begin
            ctrl.decWid = 1'b1;
            ctrl.fsSet  = 1'b1;
          end else begin
            ctrl.fsClr = 1'b1;
          end
        end
      end
    end
  end

  AST_SET_CLR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.fsSet && ctrl.fsClr)); // R6

  AST_SYNC_NO_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    syncMode |-> !(ctrl.loadPer || ctrl.decPer)); // R5

endmodule

// File: rtl/fsg_datapath.sv
module fsg_datapath
  import fsg_pkg::*;
#(
  parameter int PW = PER_W,
  parameter int WW = WID_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  fsgCtrlT       ctrl,
  input  logic [PW-1:0] periodField,
  input  logic [WW-1:0] widthField,
  output logic          perZero,
  output logic          widZero,
  output logic          frameSync
);

  logic [PW-1:0] perCount;
  logic [WW-1:0] widCount;

  fsg_downcnt #(.W(PW)) u_perCnt (
    .clk     (clk),
    .rstN    (rstN),
    .clr     (ctrl.clrAll | ctrl.clrPer),
    .load    (ctrl.loadPer),
    .dec     (ctrl.decPer),
    .loadVal (periodField),
    .count   (perCount),
    .isZero  (perZero)
  );

  fsg_downcnt #(.W(WW)) u_widCnt (
    .clk     (clk),
    .rstN    (rstN),
    .clr     (ctrl.clrAll),
    .load    (ctrl.loadWid),
    .dec     (ctrl.decWid),
    .loadVal (widthField),
    .count   (widCount),
    .isZero  (widZero)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            frameSync <= 1'b0;
    else if (ctrl.clrAll) frameSync <= 1'b0;
    else if (ctrl.fsSet)  frameSync <= 1'b1;
    else if (ctrl.fsClr)  frameSync <= 1'b0;
  end

  AST_RELOAD_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadPer |=> frameSync); // R1

  AST_PERIOD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadPer && !ctrl.clrAll) |=> (perCount == $past(periodField))); // R4

  AST_WIDTH_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadWid && !ctrl.clrAll) |=> (widCount == $past(widthField))); // R4

  AST_PER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clrPer |=> perZero); // R5

endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen
  import fsg_pkg::*;
#(
  parameter int PW = PER_W,
  parameter int WW = WID_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bitTick,
  input  logic          enable,
  input  logic          syncMode,
  input  logic [PW-1:0] periodField,
  input  logic [WW-1:0] widthField,
  input  logic          extSync,
  output logic          frameSync
);

  fsgCtrlT ctrl;
  logic    perZero;
  logic    widZero;

  fsg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bitTick  (bitTick),
    .enable   (enable),
    .syncMode (syncMode),
    .extSync  (extSync),
    .perZero  (perZero),
    .widZero  (widZero),
    .ctrl     (ctrl)
  );

  fsg_datapath #(.PW(PW), .WW(WW)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .periodField (periodField),
    .widthField  (widthField),
    .perZero     (perZero),
    .widZero     (widZero),
    .frameSync   (frameSync)
  );

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !bitTick) |=> $stable(frameSync)); // R6

  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !frameSync); // R7

  AST_WIDTH_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (enable && bitTick && !widZero) |=> frameSync); // R2

endmodule

// File: tb/frame_sync_gen_test.sv
`timescale 1ns/1ps
module frame_sync_gen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitTick = 1'b0;
  logic        enable = 1'b0;
  logic        syncMode = 1'b0;
  logic [11:0] periodField = '0;
  logic [7:0]  widthField = '0;
  logic        extSync = 1'b0;
  logic        frameSync;

  int checks = 0;
  int failures = 0;

  // reference state
  bit mArmed = 0;
  int mPhase = 1000000;
  int mPer = 1;
  int mWid = 1;
  bit mPrev = 0;
  bit mOut = 0;

  always #5 clk = ~clk;

  frame_sync_gen uut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .enable(enable),
    .syncMode(syncMode), .periodField(periodField), .widthField(widthField),
    .extSync(extSync), .frameSync(frameSync)
  );

  function automatic void modelStep();
    bit rise;
    if (!enable) begin
      mArmed = 0; mPhase = 1000000; mOut = 0;
    end else if (bitTick) begin
      rise = extSync && !mPrev;
      if (syncMode) begin
        mArmed = 0;
        if (rise) begin mPhase = 0; mWid = int'(widthField) + 1; end
        else if (mPhase < 1000000) mPhase++;
      end else begin
        if (!mArmed || mPhase == mPer - 1) begin
          mPhase = 0; mArmed = 1;
          mPer = int'(periodField) + 1; mWid = int'(widthField) + 1;
        end else mPhase++;
      end
      mOut = (mPhase < mWid);
    end
    if (bitTick) mPrev = extSync;
  endfunction

  task automatic check(input string req, input bit exp);
    checks++;
    if (frameSync !== exp) begin
      failures++;
      $display("FAIL %s frameSync actual=%b expected=%b at %0t", req, frameSync, exp, $time);
    end
  endtask

  // called at a falling edge with inputs already set
  task automatic step(input string req);
    modelStep();
    @(negedge clk);
    check(req, mOut);
  endtask

  task automatic strobes(input string req, input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      bitTick = 1'b1; step(req);
      bitTick = 1'b0;
      for (int g = 0; g < gap; g++) step(req);
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int hiCount;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    check("R8", 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R8", 1'b0);

    // R8: zero fields, active every strobe
    enable = 1'b1;
    strobes("R8", 8, 1);

    // R1/R2: period 16, width 2, with gaps between strobes (R6)
    periodField = 12'd15; widthField = 8'd1;
    strobes("R1", 48, 2);
    hiCount = 0;
    for (int i = 0; i < 32; i++) begin
      bitTick = 1'b1; step("R2"); bitTick = 1'b0;
      if (frameSync) hiCount++;
      step("R6");
    end
    checks++;
    if (hiCount != 4) begin
      failures++;
      $display("FAIL R2 high strobes actual=%0d expected=4", hiCount);
    end

    // R3: width >= period
    periodField = 12'd3; widthField = 8'd7;
    strobes("R3", 24, 0);
    periodField = 12'd4; widthField = 8'd4;
    strobes("R3", 20, 1);

    // R4: field change mid frame
    periodField = 12'd9; widthField = 8'd4;
    strobes("R4", 12, 0);
    periodField = 12'd2; widthField = 8'd0;
    strobes("R4", 14, 0);

    // R7: disable drops output in one clock, restart on first strobe
    periodField = 12'd7; widthField = 8'd3;
    strobes("R7", 3, 0);
    enable = 1'b0; step("R7"); step("R7");
    bitTick = 1'b1; step("R7"); bitTick = 1'b0;
    enable = 1'b1;
    strobes("R7", 10, 0);

    // R5: triggered mode, period ignored
    syncMode = 1'b1; widthField = 8'd2;
    for (int k = 0; k < 4; k++) begin
      periodField = 12'($urandom_range(0, 4095));
      extSync = 1'b1; strobes("R5", 2, 0);
      extSync = 1'b0; strobes("R5", 6 + k, 1);
    end
    syncMode = 1'b0;
    strobes("R5", 6, 0);

    // constrained random mix
    for (int i = 0; i < 6000; i++) begin
      bitTick = ($urandom_range(0, 2) != 0);
      if ($urandom_range(0, 99) == 0) enable = ~enable;
      if (!enable && $urandom_range(0, 3) == 0) enable = 1'b1;
      if ($urandom_range(0, 299) == 0) syncMode = ~syncMode;
      if ($urandom_range(0, 9) == 0) extSync = ~extSync;
      if ($urandom_range(0, 49) == 0) periodField = 12'($urandom_range(0, 20));
      if ($urandom_range(0, 49) == 0) widthField = 8'($urandom_range(0, 20));
      step(syncMode ? "R5" : "R1");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule